// File: doc/BRIEF.md
# Exponent Window Splitter

This block takes an exponent of a fixed bit width and cuts it into a series of windows for a sliding-window exponentiation engine. It reads one exponent bit per clock cycle, starting at the top bit and moving down. Each window goes out on a valid/ready stream. A window is either a run of zeros of any length, or a nonzero group of at most `WIN_MAX` bits that always ends in a 1. The exponentiation engine then squares once per window bit and multiplies by a precomputed odd power for each nonzero window.

Zeros above the highest set bit are skipped, so the first window is always nonzero. The only exception is an exponent that is entirely zero. While a nonzero window is open, a run of `ZRUN` zeros closes it. A window that reaches `WIN_MAX` bits also closes. In both cases the trailing zeros of the closed window move into the next zero window. As a result, the window lengths add up to the number of bits scanned, and joining the window values in order gives back the exponent. A new exponent is accepted only while the block is idle.

Top module: `exp_window_part`

## Requirements
- R1: Bits are consumed from the top bit toward bit 0. Joining the emitted windows in order (shift left by `win_len`, OR in `win_value`) gives back the loaded exponent. The `win_len` values add up to the bit position of the highest set bit plus one.
- R2: For a nonzero exponent, zeros above the highest set bit produce no window, and the first window has `win_zero` = 0. An all-zero exponent produces exactly one window: `win_zero` = 1, `win_value` = 0, `win_len` = `EXP_W`, `win_last` = 1.
- R3: Every window with `win_zero` = 0 has bit 0 of `win_value` equal to 1 and a length from 1 to `WIN_MAX`.
- R4: An open nonzero window closes as soon as its newest `ZRUN` bits are all zero. Those zeros start the next zero window. A zero window has no length limit, and it carries `win_zero` = 1 and `win_value` = 0.
- R5: A nonzero window closes when it holds `WIN_MAX` bits. Any zeros at its low end (fewer than `ZRUN`) are removed and start the next zero window. If the window ends in a 1, the next window starts at the next set bit.
- R6: `win_last` is 1 on the final window of each exponent and 0 on every other window.
- R7: While `win_valid` = 1 and `win_ready` = 0, the window fields and `win_valid` hold their values.
- R8: `start` loads `exp_in` only while `idle` = 1. `idle` falls at that load and rises again once the final window has been formed. A `start` pulse while busy has no effect on the windows.
- R9: During and right after reset, `idle` = 1 and `win_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load `exp_in` when idle |
| exp_in | input | EXP_W | Exponent to split |
| idle | output | 1 | Ready to accept a new exponent |
| win_valid | output | 1 | A window is presented |
| win_ready | input | 1 | Consumer accepts the window |
| win_value | output | WIN_MAX | Window bits, right aligned; zero for a zero window |
| win_len | output | clog2(EXP_W+1) | Number of exponent bits the window covers |
| win_zero | output | 1 | 1 = zero window, 0 = nonzero window |
| win_last | output | 1 | Final window of the exponent |

## Verification
The bench targets the edges where a window closes:
- A zero run that reaches `ZRUN` exactly at the final bit. A design that flushed naively here would emit a window ending in 0, or drop the zeros and break the length sum.
- A window that fills to `WIN_MAX` with trailing zeros. If those zeros were not stripped, the odd-value rule would fail.
- A window that fills to `WIN_MAX` on the very last bit. Missing this case leaves the final window without its last flag.
- The all-zero exponent and a lone top bit. These catch broken handling of leading zeros.

Random stalls on `win_ready` and a `start` pulse during a busy scan expose windows that change while stalled and reloads that corrupt the reconstruction.

// File: rtl/win_part_pkg.sv
package win_part_pkg;
   typedef enum logic [1:0] {
      PS_IDLE,
      PS_LEAD,
      PS_ZERO,
      PS_NONZ
   } part_state_e;
endpackage

// File: rtl/exp_bit_feed.sv
module exp_bit_feed #(
   parameter int EXP_W = 32,
   parameter int LW    = $clog2(EXP_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [EXP_W-1:0] exp_in,
   input  logic             step,
   output logic             cur_bit,
   output logic [LW-1:0]    bits_left
);
   logic [EXP_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q      <= '0;
         bits_left <= '0;
      end else if (load) begin
         sh_q      <= exp_in;
         bits_left <= LW'(EXP_W);
      end else if (step) begin
         sh_q      <= {sh_q[EXP_W-2:0], 1'b0};
         bits_left <= bits_left - LW'(1);
      end
   end

   assign cur_bit = sh_q[EXP_W-1];

   AST_FEED_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> bits_left != '0);  // R1
endmodule

// File: rtl/nz_accum.sv
module nz_accum #(
   parameter int WIN_MAX = 5,
   parameter int ZRUN    = 2,
   parameter int KW      = $clog2(WIN_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               seed,
   input  logic               push,
   input  logic               bit_in,
   output logic [WIN_MAX-1:0] cur_val,
   output logic [KW-1:0]      cur_len,
   output logic [KW-1:0]      cur_tz,
   output logic [WIN_MAX-1:0] nxt_val,
   output logic [KW-1:0]      nxt_len,
   output logic [KW-1:0]      nxt_tz
);
   localparam logic [KW-1:0] K_L = KW'(WIN_MAX);
   localparam logic [KW-1:0] Q_L = KW'(ZRUN);

   always_comb begin
      nxt_val = {cur_val[WIN_MAX-2:0], bit_in};
      nxt_len = cur_len + KW'(1);
      nxt_tz  = bit_in ? '0 : cur_tz + KW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cur_val <= '0;
         cur_len <= '0;
         cur_tz  <= '0;
      end else if (seed) begin
         cur_val <= WIN_MAX'(1);
         cur_len <= KW'(1);
         cur_tz  <= '0;
      end else if (push) begin
         cur_val <= nxt_val;
         cur_len <= nxt_len;
         cur_tz  <= nxt_tz;
      end
   end

   AST_ACC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      cur_len <= K_L);  // R5
   AST_ACC_ZRUN: assert property (@(posedge clk) disable iff (!rst_n)
      cur_tz <= Q_L);  // R4
   AST_ACC_LEADS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      cur_len != '0 |-> cur_val != '0);  // R3
endmodule

// File: rtl/exp_window_part.sv
module exp_window_part
   import win_part_pkg::*;
#(
   parameter int EXP_W   = 32,
   parameter int WIN_MAX = 5,
   parameter int ZRUN    = 2,
   localparam int LW     = $clog2(EXP_W + 1),
   localparam int KW     = $clog2(WIN_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [EXP_W-1:0]   exp_in,
   output logic               idle,
   output logic               win_valid,
   input  logic               win_ready,
   output logic [WIN_MAX-1:0] win_value,
   output logic [LW-1:0]      win_len,
   output logic               win_zero,
   output logic               win_last
);
   localparam logic [KW-1:0] K_L = KW'(WIN_MAX);
   localparam logic [KW-1:0] Q_L = KW'(ZRUN);

   if (ZRUN < 2 || ZRUN > 5) begin : g_bad_zrun
      $error("ZRUN must lie in 2..5");
   end
   if (WIN_MAX < 2 || WIN_MAX < ZRUN) begin : g_bad_win
      $error("WIN_MAX must be at least 2 and at least ZRUN");
   end
   if (EXP_W < WIN_MAX) begin : g_bad_exp
      $error("EXP_W must be at least WIN_MAX");
   end

   part_state_e state_q, state_n;
   logic [LW-1:0] zcnt_q, zcnt_n;
   logic          load, step, cur_bit;
   logic [LW-1:0] bits_left;
   logic          acc_clr, acc_seed, acc_push;
   logic [WIN_MAX-1:0] cur_val, nxt_val;
   logic [KW-1:0]      cur_len, cur_tz, nxt_len, nxt_tz;
   logic               emit, e_zero, e_last;
   logic [WIN_MAX-1:0] e_val;
   logic [LW-1:0]      e_len;
   logic               adv, has_bit, more;

   exp_bit_feed #(.EXP_W(EXP_W), .LW(LW)) u_feed (
      .clk(clk), .rst_n(rst_n), .load(load), .exp_in(exp_in), .step(step),
      .cur_bit(cur_bit), .bits_left(bits_left));

   nz_accum #(.WIN_MAX(WIN_MAX), .ZRUN(ZRUN), .KW(KW)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(acc_clr), .seed(acc_seed), .push(acc_push),
      .bit_in(cur_bit), .cur_val(cur_val), .cur_len(cur_len), .cur_tz(cur_tz),
      .nxt_val(nxt_val), .nxt_len(nxt_len), .nxt_tz(nxt_tz));

   assign adv     = !win_valid || win_ready;
   assign has_bit = bits_left != '0;
   assign more    = bits_left > LW'(1);
   assign idle    = state_q == PS_IDLE;

   always_comb begin
      state_n  = state_q;
      zcnt_n   = zcnt_q;
      load     = 1'b0;
      step     = 1'b0;
      acc_clr  = 1'b0;
      acc_seed = 1'b0;
      acc_push = 1'b0;
      emit     = 1'b0;
      e_val    = '0;
      e_len    = '0;
      e_zero   = 1'b0;
      e_last   = 1'b0;
      unique case (state_q)
         PS_IDLE: if (start) begin
            load    = 1'b1;
            state_n = PS_LEAD;
         end
         PS_LEAD: if (adv) begin
            if (!has_bit) begin
               emit    = 1'b1;
               e_zero  = 1'b1;
               e_len   = LW'(EXP_W);
               e_last  = 1'b1;
               state_n = PS_IDLE;
            end else begin
               step = 1'b1;
               if (cur_bit) begin
                  acc_seed = 1'b1;
                  state_n  = PS_NONZ;
               end
            end
         end
         PS_ZERO: if (adv) begin
            if (!has_bit) begin
               emit    = 1'b1;
               e_zero  = 1'b1;
               e_len   = zcnt_q;
               e_last  = 1'b1;
               state_n = PS_IDLE;
            end else begin
               step = 1'b1;
               if (cur_bit) begin
                  emit     = zcnt_q != '0;
                  e_zero   = 1'b1;
                  e_len    = zcnt_q;
                  acc_seed = 1'b1;
                  zcnt_n   = '0;
                  state_n  = PS_NONZ;
               end else begin
                  zcnt_n = zcnt_q + LW'(1);
               end
            end
         end
         PS_NONZ: if (adv) begin
            if (!has_bit) begin
               emit    = 1'b1;
               e_val   = cur_val >> cur_tz;
               e_len   = LW'(cur_len - cur_tz);
               e_last  = cur_tz == '0;
               acc_clr = 1'b1;
               zcnt_n  = LW'(cur_tz);
               state_n = (cur_tz == '0) ? PS_IDLE : PS_ZERO;
            end else begin
               step = 1'b1;
               if (cur_len == '0) begin
                  if (cur_bit) acc_seed = 1'b1;
                  else begin
                     zcnt_n  = LW'(1);
                     state_n = PS_ZERO;
                  end
               end else if (more && (nxt_tz == Q_L || nxt_len == K_L)) begin
                  emit    = 1'b1;
                  e_val   = nxt_val >> nxt_tz;
                  e_len   = LW'(nxt_len - nxt_tz);
                  acc_clr = 1'b1;
                  zcnt_n  = LW'(nxt_tz);
                  state_n = (nxt_tz == '0) ? PS_NONZ : PS_ZERO;
               end else begin
                  acc_push = 1'b1;
               end
            end
         end
         default: state_n = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= PS_IDLE;
         zcnt_q    <= '0;
         win_valid <= 1'b0;
         win_value <= '0;
         win_len   <= '0;
         win_zero  <= 1'b0;
         win_last  <= 1'b0;
      end else begin
         state_q <= state_n;
         zcnt_q  <= zcnt_n;
         if (emit) begin
            win_valid <= 1'b1;
            win_value <= e_val;
            win_len   <= e_len;
            win_zero  <= e_zero;
            win_last  <= e_last;
         end else if (win_ready) begin
            win_valid <= 1'b0;
         end
      end
   end

   AST_NZ_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid && !win_zero |-> win_value[0]);  // R3
   AST_NZ_MAXLEN: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid && !win_zero |-> (win_len != '0 && win_len <= LW'(WIN_MAX)));  // R5
   AST_ZW_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid && win_zero |-> (win_value == '0 && win_len != '0));  // R4
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid && !win_ready |=> win_valid && $stable(win_value) && $stable(win_len)
                                  && $stable(win_zero) && $stable(win_last));  // R7
   AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> !load);  // R8
endmodule

// File: tb/exp_window_part_test.sv
`timescale 1ns/1ps
module exp_window_part_test;
   localparam int EXP_W = 16;
   localparam int K     = 4;
   localparam int Q     = 2;
   localparam int LW    = $clog2(EXP_W + 1);

   typedef struct packed {
      logic [K-1:0]  v;
      logic [LW-1:0] l;
      logic          z;
      logic          last;
   } win_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [EXP_W-1:0] exp_in = '0;
   logic idle, win_valid, win_zero, win_last;
   logic win_ready = 1'b0;
   logic [K-1:0] win_value;
   logic [LW-1:0] win_len;

   always #2 clk = ~clk;

   exp_window_part #(.EXP_W(EXP_W), .WIN_MAX(K), .ZRUN(Q)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .exp_in(exp_in), .idle(idle),
      .win_valid(win_valid), .win_ready(win_ready), .win_value(win_value),
      .win_len(win_len), .win_zero(win_zero), .win_last(win_last));

   int n_checks = 0;
   int n_fail = 0;
   int done_cnt = 0;
   int cycles = 0;
   int rdy_mode = 0;
   logic [15:0] rlfsr = 16'hACE1;
   win_t exp_q[$];
   logic [EXP_W-1:0] cur_exp = '0;
   int exp_bits = 0;
   logic [63:0] rc = '0;
   int sumlen = 0;
   bit first_win = 1'b1;
   bit prev_stall = 1'b0;
   win_t prev_w;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // Reference split from the requirements; pushes expected windows
   task automatic model(input logic [EXP_W-1:0] e);
      win_t lst[$];
      int top = -1;
      bit inz = 0;
      int av = 0, al = 0, tz = 0, zc = 0;
      for (int i = EXP_W - 1; i >= 0; i--) if (e[i] && top < 0) top = i;
      if (top < 0) begin
         exp_q.push_back('{v: '0, l: LW'(EXP_W), z: 1'b1, last: 1'b1});
         exp_bits = EXP_W;
         return;
      end
      exp_bits = top + 1;
      for (int i = top; i >= 0; i--) begin
         if (!inz) begin
            if (e[i]) begin
               if (zc > 0) lst.push_back('{v: '0, l: LW'(zc), z: 1'b1, last: 1'b0});
               zc = 0; inz = 1; av = 1; al = 1; tz = 0;
            end else zc++;
         end else if (al == 0) begin
            if (e[i]) begin av = 1; al = 1; tz = 0; end
            else begin inz = 0; zc = 1; end
         end else begin
            av = av * 2 + int'(e[i]); al++; tz = e[i] ? 0 : tz + 1;
            if (i > 0 && (tz == Q || al == K)) begin
               lst.push_back('{v: K'(av >> tz), l: LW'(al - tz), z: 1'b0, last: 1'b0});
               if (tz > 0) begin inz = 0; zc = tz; end
               else al = 0;
            end
         end
      end
      if (inz && al > 0) begin
         lst.push_back('{v: K'(av >> tz), l: LW'(al - tz), z: 1'b0, last: 1'b0});
         zc = tz;
      end else if (inz) zc = 0;
      if (zc > 0) lst.push_back('{v: '0, l: LW'(zc), z: 1'b1, last: 1'b0});
      lst[lst.size() - 1].last = 1'b1;
      foreach (lst[j]) exp_q.push_back(lst[j]);
   endtask

   // Monitor and ready driver
   always @(negedge clk) begin
      win_t got, want;
      if (!rst_n) win_ready = 1'b0;
      else if (rdy_mode == 0) win_ready = 1'b1;
      else begin
         rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
         win_ready = rlfsr[0] | rlfsr[3];
      end
      got = '{v: win_value, l: win_len, z: win_zero, last: win_last};
      if (rst_n && prev_stall)
         chk(win_valid && got == prev_w, "R7 stall hold", {got, win_valid}, {prev_w, 1'b1});
      prev_stall = rst_n && win_valid && !win_ready;
      prev_w = got;
      if (rst_n && win_valid && win_ready) begin
         if (exp_q.size() == 0) chk(1'b0, "R1 unexpected window", got, 0);
         else begin
            want = exp_q.pop_front();
            chk(got == want, "R3 R4 R5 R6 window fields", got, want);
            if (first_win && cur_exp != '0)
               chk(!win_zero, "R2 first window nonzero", win_zero, 0);
            first_win = 1'b0;
            rc = (rc << win_len) | 64'(win_value);
            sumlen += int'(win_len);
            if (win_last) begin
               chk(rc == 64'(cur_exp), "R1 rebuilt exponent", rc, 64'(cur_exp));
               chk(sumlen == exp_bits, "R1 length sum", sumlen, exp_bits);
               rc = '0; sumlen = 0; first_win = 1'b1;
               done_cnt++;
            end
         end
      end
   end

   task automatic run_exp(input logic [EXP_W-1:0] e, input bit poke_busy);
      int target;
      while (!idle) @(negedge clk);
      model(e);
      cur_exp = e;
      target = done_cnt + 1;
      start = 1'b1; exp_in = e;
      @(negedge clk);
      start = 1'b0;
      chk(!idle, "R8 idle falls on load", idle, 0);
      if (poke_busy) begin
         @(negedge clk);
         @(negedge clk);
         start = 1'b1; exp_in = ~e;
         @(negedge clk);
         start = 1'b0; exp_in = '0;
      end
      while (done_cnt < target) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] x = 16'h1D2B;
      repeat (3) @(negedge clk);
      chk(idle == 1'b1, "R9 idle in reset", idle, 1);
      chk(win_valid == 1'b0, "R9 no window in reset", win_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(idle == 1'b1 && win_valid == 1'b0, "R9 after reset", {idle, win_valid}, 2'b10);
      run_exp(16'h0000, 0);  // R2 all zero
      run_exp(16'h0001, 0);  // R2 lone low bit
      run_exp(16'h8000, 0);  // R4 long zero tail
      run_exp(16'hFFFF, 0);  // R5 full windows, last fills at bit 0
      run_exp(16'd1903, 0);  // R5 strip at limit
      run_exp(16'h8001, 0);
      run_exp(16'hC002, 0);  // R4 zero run at final bits
      run_exp(16'h9249, 0);
      run_exp(16'hF0F0, 0);
      run_exp(16'hA5A5, 1);  // R8 start while busy
      rdy_mode = 1;
      run_exp(16'h7B6D, 1);  // R7 with stalls
      for (int i = 0; i < 24; i++) begin
         x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
         run_exp(x, i[0]);
      end
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6 no pending windows", exp_q.size(), 0);
      chk(idle == 1'b1, "R8 idle after run", idle, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule